// File: doc/BRIEF.md
# Paired-Register I2C Write Engine

This block is the write path of an I2C slave that holds eight 8-bit registers grouped into four pairs: input port (0/1), output port (2/3), polarity inversion (4/5) and configuration (6/7). It consumes bus events that a START/STOP detector and a bit shifter have already decoded: a start pulse, a stop pulse, and a received-byte strobe with its value. Three strap inputs complete the device address.

The first byte after a START is checked against the address. On a match for a write, the next byte is the command that selects a register. Each data byte after that is stored at the selected register. The pointer then moves to the other register of the same pair, so a long burst alternates between the two halves of one pair until STOP. For every byte the engine takes part in, it reports an acknowledge decision one cycle after the byte strobe. The contents of the writable registers appear on three 16-bit outputs.

Top module: `i2c_pair_write_engine`

## Requirements
- R1: An address byte whose bits [7:4] are 0100, whose bits [3:1] equal `strap`, and whose bit 0 is 0 is acknowledged (`ack_valid`=1, `ack`=1), and the following byte is taken as the command byte.
- R2: An address byte that does not match, or whose bit 0 is 1, gets `ack_valid`=1 with `ack`=0. Every later byte up to the next START gets no `ack_valid` and writes nothing.
- R3: Bits [2:0] of the command byte select register index 0 to 7, and its bits [7:3] are ignored. The command byte is acknowledged.
- R4: After each stored data byte the register index flips its bit 0 (3 goes to 2, 2 goes to 3, and so on), for any number of data bytes until STOP or START.
- R5: Index 2 drives `out_port[7:0]` and index 3 drives `out_port[15:8]`. Index 4 and 5 drive the low and high bytes of `pol_inv`. Index 6 and 7 drive the low and high bytes of `dir_cfg`.
- R6: Each address, command and data byte of a selected transaction produces exactly one `ack_valid` pulse, in the cycle after its `rx_valid`. `ack_valid` is never high without a byte in the cycle before it.
- R7: Data bytes aimed at index 0 or 1 are acknowledged but change no output.
- R8: After reset, `out_port`=16'hFFFF, `pol_inv`=16'h0000 and `dir_cfg`=16'hFFFF.
- R9: After STOP, bytes get no `ack_valid` and write nothing until the next START.
- R10: A START in the middle of a data burst returns the engine to the address phase, so the next byte is decoded as an address and not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_start | input | 1 | One-cycle pulse for a START or repeated START; has priority over the other events |
| bus_stop | input | 1 | One-cycle pulse for a STOP |
| rx_valid | input | 1 | A received byte is present on `rx_byte` |
| rx_byte | input | 8 | Received byte, MSB first as on the bus |
| strap | input | 3 | Address select straps, matched against address bits [3:1] |
| ack_valid | output | 1 | An acknowledge decision is present |
| ack | output | 1 | 1 = acknowledge, 0 = not acknowledge (0 when `ack_valid` is 0) |
| out_port | output | 16 | Output port pair, {index 3, index 2} |
| pol_inv | output | 16 | Polarity inversion pair, {index 5, index 4} |
| dir_cfg | output | 16 | Configuration pair, {index 7, index 6} |

## Verification
The main function is exercised with bursts that start on the high register of a pair (3, then 2), bursts that start on the low register (4, then 5) with a command byte whose upper bits are set, and bursts of two bytes. The final register values show whether the pointer alternated rather than incremented, and whether the upper command bits were ignored. Address bytes with the read bit set, with the wrong strap value and with a matching write are compared on the acknowledge output. Stray bytes after STOP, writes to the input pair and a repeated START in the middle of a burst are each followed by a readback of all three outputs, which shows that none of them reached a register.

// File: rtl/i2cpw_pkg.sv
// Package for the paired-register write engine.
// Holds the transaction phase encoding and the index of each register pair.
// Assumes the register index has three bits, so there are four pairs.
package i2cpw_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,   // no transaction, or finished after STOP
        PH_ADDR = 3'd1,   // next byte is the device address
        PH_CMD  = 3'd2,   // next byte selects the register
        PH_DATA = 3'd3,   // bytes are stored, pointer alternates within the pair
        PH_SKIP = 3'd4    // not addressed, stay silent until START
    } phase_t;

    localparam int PAIR_IN  = 0;
    localparam int PAIR_OUT = 1;
    localparam int PAIR_POL = 2;
    localparam int PAIR_CFG = 3;

endpackage

// File: rtl/i2cpw_addr_match.sv
// Device address comparator.
// Says whether a byte is this slave's write address: a fixed prefix, then the
// strap bits, then a direction bit of 0. Purely combinational. The caller
// decides when the byte really is an address byte.
module i2cpw_addr_match #(
    parameter int DATA_W      = 8,
    parameter int STRAP_W     = 3,
    parameter int ADDR_PREFIX = 4,
    localparam int PREFIX_W   = DATA_W - 1 - STRAP_W
) (
    input  logic [DATA_W-1:0]  byte_i,
    input  logic [STRAP_W-1:0] strap_i,
    output logic               hit_o
);

    logic prefix_ok;
    logic strap_ok;
    logic is_write;

    // Compare each address field with the value it must carry.
    always_comb begin
        prefix_ok = (byte_i[DATA_W-1 -: PREFIX_W] == PREFIX_W'(ADDR_PREFIX));
        strap_ok  = (byte_i[STRAP_W:1] == strap_i);
        is_write  = ~byte_i[0];
        hit_o     = prefix_ok & strap_ok & is_write;
    end

endmodule

// File: rtl/i2cpw_phase_ctrl.sv
// Transaction sequencer.
// Tracks the phase of the transaction (address, command, data), owns the
// register pointer, and issues one acknowledge decision per byte it takes part
// in. The pointer alternates between the two registers of a pair by flipping
// bit 0. Assumes START, STOP and byte strobes are one-cycle pulses.
// Priority: START over STOP over byte.
module i2cpw_phase_ctrl
    import i2cpw_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              addr_hit,
    output logic              ack_valid,
    output logic              ack,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data
);

    phase_t           phase;
    logic [IDX_W-1:0] ptr;
    logic             byte_evt;

    // A byte counts only when no bus condition arrives in the same cycle.
    always_comb begin
        byte_evt = rx_valid & ~bus_start & ~bus_stop;
    end

    // Advance the phase, load or flip the pointer, and register the ack decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            ptr       <= '0;
            ack_valid <= 1'b0;
            ack       <= 1'b0;
        end else begin
            ack_valid <= 1'b0;
            ack       <= 1'b0;
            if (bus_start) begin
                phase <= PH_ADDR;
            end else if (bus_stop) begin
                phase <= PH_IDLE;
            end else if (rx_valid) begin
                case (phase)
                    PH_ADDR: begin
                        ack_valid <= 1'b1;
                        ack       <= addr_hit;
                        phase     <= addr_hit ? PH_CMD : PH_SKIP;
                    end
                    PH_CMD: begin
                        ack_valid <= 1'b1;
                        ack       <= 1'b1;
                        ptr       <= rx_byte[IDX_W-1:0];
                        phase     <= PH_DATA;
                    end
                    PH_DATA: begin
                        ack_valid <= 1'b1;
                        ack       <= 1'b1;
                        ptr       <= {ptr[IDX_W-1:1], ~ptr[0]};
                    end
                    default: begin
                        phase <= phase;
                    end
                endcase
            end
        end
    end

    // Present the data byte and its target to the register bank.
    always_comb begin
        wr_en   = byte_evt && (phase == PH_DATA);
        wr_idx  = ptr;
        wr_data = rx_byte;
    end

    // An ack decision always follows a byte strobe one cycle earlier.
    p_ack_follows_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> $past(rx_valid));

    // A missed address gets a NACK and the engine goes silent.
    p_nack_on_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_ADDR && byte_evt && !addr_hit) |=> (ack_valid && !ack && phase == PH_SKIP));

    // While skipping, no byte gets an ack decision.
    p_skip_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SKIP && !bus_start) |=> !ack_valid);

    // After STOP, bytes are not answered until a START.
    p_idle_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && !bus_start) |=> !ack_valid);

    // A data byte moves the pointer to the partner register in the same pair.
    p_pair_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ptr[0] != $past(ptr[0]) && ptr[IDX_W-1:1] == $past(ptr[IDX_W-1:1])));

    // START always takes the engine back to the address phase.
    p_start_to_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |=> (phase == PH_ADDR));

endmodule

// File: rtl/i2cpw_reg_bank.sv
// Storage for the writable register pairs.
// Generates one 8-bit register for each index of pairs 1 to 3. The input pair
// (index 0/1) has no storage, so writes to it are dropped here. The polarity
// pair resets to zeros and the other pairs to ones. Output is packed from
// index 2 upward.
module i2cpw_reg_bank
    import i2cpw_pkg::*;
#(
    parameter int REG_W = 8,
    parameter int IDX_W = 3,
    localparam int NREG   = 1 << IDX_W,
    localparam int NPAIR  = NREG / 2,
    localparam int STORED = NREG - 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [REG_W-1:0]        wr_data,
    output logic [STORED*REG_W-1:0] regs_o
);

    for (genvar p = PAIR_OUT; p < NPAIR; p++) begin : g_pair
        for (genvar h = 0; h < 2; h++) begin : g_half
            localparam int IDX = 2 * p + h;
            localparam logic [REG_W-1:0] RST_VAL = (p == PAIR_POL) ? '0 : '1;
            logic [REG_W-1:0] q;

            // Load this register when the write targets its index.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= RST_VAL;
                end else if (wr_en && wr_idx == IDX_W'(IDX)) begin
                    q <= wr_data;
                end
            end

            assign regs_o[(IDX-2)*REG_W +: REG_W] = q;
        end
    end

    // A write to the read-only input pair leaves every stored register as it was.
    p_input_pair_ro_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx[IDX_W-1:1] == '0) |=> $stable(regs_o));

    // A write to a stored index lands in that register.
    p_write_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx[IDX_W-1:1] != '0) |=>
            (regs_o[($past(wr_idx) - IDX_W'(2)) * REG_W +: REG_W] == $past(wr_data)));

endmodule

// File: rtl/i2c_pair_write_engine.sv
// Top of the paired-register I2C write engine.
// Joins the address comparator, the transaction sequencer and the register
// bank, and splits the bank into the three pair outputs. Assumes bus events
// come from a front end that is already synchronous to clk.
module i2c_pair_write_engine #(
    parameter int DATA_W      = 8,
    parameter int IDX_W       = 3,
    parameter int STRAP_W     = 3,
    parameter int ADDR_PREFIX = 4,
    localparam int NREG   = 1 << IDX_W,
    localparam int STORED = NREG - 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_start,
    input  logic               bus_stop,
    input  logic               rx_valid,
    input  logic [DATA_W-1:0]  rx_byte,
    input  logic [STRAP_W-1:0] strap,
    output logic               ack_valid,
    output logic               ack,
    output logic [2*DATA_W-1:0] out_port,
    output logic [2*DATA_W-1:0] pol_inv,
    output logic [2*DATA_W-1:0] dir_cfg
);

    logic                     addr_hit;
    logic                     wr_en;
    logic [IDX_W-1:0]         wr_idx;
    logic [DATA_W-1:0]        wr_data;
    logic [STORED*DATA_W-1:0] regs;

    i2cpw_addr_match #(
        .DATA_W     (DATA_W),
        .STRAP_W    (STRAP_W),
        .ADDR_PREFIX(ADDR_PREFIX)
    ) u_addr (
        .byte_i (rx_byte),
        .strap_i(strap),
        .hit_o  (addr_hit)
    );

    i2cpw_phase_ctrl #(
        .DATA_W(DATA_W),
        .IDX_W (IDX_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_start(bus_start),
        .bus_stop (bus_stop),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .addr_hit (addr_hit),
        .ack_valid(ack_valid),
        .ack      (ack),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data)
    );

    i2cpw_reg_bank #(
        .REG_W(DATA_W),
        .IDX_W(IDX_W)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_data(wr_data),
        .regs_o (regs)
    );

    // Route each stored pair to its output: out (2/3), polarity (4/5), config (6/7).
    always_comb begin
        out_port = regs[0*DATA_W +: 2*DATA_W];
        pol_inv  = regs[2*DATA_W +: 2*DATA_W];
        dir_cfg  = regs[4*DATA_W +: 2*DATA_W];
    end

endmodule

// File: tb/tb_i2c_pair_write_engine.sv
// Bench for the paired-register write engine: a vector table walked by one
// loop, then directed checks of register contents, restart and reset.
module tb_i2c_pair_write_engine;

    localparam logic [1:0] OB = 2'd0;  // byte
    localparam logic [1:0] OS = 2'd1;  // START
    localparam logic [1:0] OP = 2'd2;  // STOP
    localparam int NV = 35;

    // {op, byte, expected ack_valid, expected ack}; strap = 3'b101 -> write address 8'h4A
    localparam logic [11:0] VEC [NV] = '{
        {OS, 8'h00, 2'b00},
        {OB, 8'h4A, 2'b11},  // R1 match
        {OB, 8'h03, 2'b11},  // R3 command -> index 3
        {OB, 8'h11, 2'b11},  // index 3
        {OB, 8'h22, 2'b11},  // index 2 (R4)
        {OB, 8'h33, 2'b11},  // index 3
        {OB, 8'h44, 2'b11},  // index 2
        {OP, 8'h00, 2'b00},
        {OB, 8'h55, 2'b00},  // R9 after STOP
        {OS, 8'h00, 2'b00},
        {OB, 8'h4B, 2'b10},  // R2 read bit set
        {OB, 8'hFC, 2'b00},
        {OB, 8'h00, 2'b00},
        {OS, 8'h00, 2'b00},
        {OB, 8'h48, 2'b10},  // R2 wrong strap
        {OB, 8'h01, 2'b00},
        {OS, 8'h00, 2'b00},
        {OB, 8'h4A, 2'b11},
        {OB, 8'hFC, 2'b11},  // R3 upper bits ignored -> index 4
        {OB, 8'hA5, 2'b11},  // index 4
        {OB, 8'h5A, 2'b11},  // index 5
        {OB, 8'h0F, 2'b11},  // index 4
        {OP, 8'h00, 2'b00},
        {OS, 8'h00, 2'b00},
        {OB, 8'h4A, 2'b11},
        {OB, 8'h07, 2'b11},  // index 7
        {OB, 8'h81, 2'b11},  // index 7
        {OB, 8'h7E, 2'b11},  // index 6
        {OP, 8'h00, 2'b00},
        {OS, 8'h00, 2'b00},
        {OB, 8'h4A, 2'b11},
        {OB, 8'h01, 2'b11},  // index 1, input pair
        {OB, 8'hBB, 2'b11},  // R7 acked, discarded
        {OB, 8'hCC, 2'b11},  // R7 acked, discarded
        {OP, 8'h00, 2'b00}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_start = 1'b0;
    logic        bus_stop = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic [2:0]  strap = 3'b101;
    logic        ack_valid;
    logic        ack;
    logic [15:0] out_port;
    logic [15:0] pol_inv;
    logic [15:0] dir_cfg;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    i2c_pair_write_engine dut (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .strap(strap),
        .ack_valid(ack_valid), .ack(ack),
        .out_port(out_port), .pol_inv(pol_inv), .dir_cfg(dir_cfg)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one event for one cycle; return at the next falling edge with the
    // registered response visible.
    task automatic do_op(input logic [1:0] op, input logic [7:0] b);
        @(negedge clk);
        bus_start = (op == OS);
        bus_stop  = (op == OP);
        rx_valid  = (op == OB);
        rx_byte   = b;
        @(negedge clk);
        bus_start = 1'b0;
        bus_stop  = 1'b0;
        rx_valid  = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        do_reset();
        // R8 reset state
        chk("R8 out_port", 32'(out_port), 32'h0000_FFFF);
        chk("R8 pol_inv", 32'(pol_inv), 32'h0000_0000);
        chk("R8 dir_cfg", 32'(dir_cfg), 32'h0000_FFFF);
        chk("R6 no ack at rest", 32'({ack_valid, ack}), 32'h0);

        // R1 R2 R3 R6 R9: walk the vector table
        for (int i = 0; i < NV; i++) begin
            do_op(VEC[i][11:10], VEC[i][9:2]);
            chk($sformatf("R6 vec%0d ack_valid/ack", i), 32'({ack_valid, ack}), 32'(VEC[i][1:0]));
        end

        // R4 R5 R9: alternate-in-pair contents; R7: input-pair writes left all three alone
        chk("R4 R5 R9 out_port", 32'(out_port), 32'h0000_3344);
        chk("R4 R5 R3 pol_inv", 32'(pol_inv), 32'h0000_5A0F);
        chk("R4 R5 dir_cfg", 32'(dir_cfg), 32'h0000_817E);

        // R10: repeated START mid-burst; the next byte is an address, not data
        do_op(OS, 8'h00);
        do_op(OB, 8'h4A);
        do_op(OB, 8'h02);
        do_op(OB, 8'h11);  // index 2
        do_op(OS, 8'h00);
        do_op(OB, 8'h4A);
        chk("R10 address acked after restart", 32'({ack_valid, ack}), 32'h3);
        do_op(OB, 8'h06);
        chk("R10 command acked", 32'({ack_valid, ack}), 32'h3);
        do_op(OP, 8'h00);
        chk("R10 out_port", 32'(out_port), 32'h0000_3311);
        chk("R10 dir_cfg", 32'(dir_cfg), 32'h0000_817E);

        // R8 again after a second reset
        do_reset();
        chk("R8 out_port again", 32'(out_port), 32'h0000_FFFF);
        chk("R8 pol_inv again", 32'(pol_inv), 32'h0000_0000);
        chk("R8 dir_cfg again", 32'(dir_cfg), 32'h0000_FFFF);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule